// File: doc/BRIEF.md
# Display Interrupt Control and Status Register

This block is one 32-bit register that a display controller exposes to its host for interrupt handling. Three single-cycle event pulses from the display timing logic (frame finished, vertical sync begins, vertical sync ends) each set a sticky status flag. Three enable bits in the same word pick which flags may raise the interrupt. A single level interrupt line goes to the host and stays high while any enabled flag is set.

The host reaches the register through a plain register port with a write strobe, a read strobe and 32-bit data in each direction. One write does two jobs. It acknowledges flags by writing zero to their positions, and in the same access it loads all three enables. An interrupt handler can therefore clear what it serviced and switch off one source in a single store, while leaving the other enables as they were by writing them back as ones. A flag position written with one is left alone. An event that lands in the same cycle as an acknowledge is never lost.

Reset is taken asynchronously and released through a small synchronizer. Writing the whole word to zero returns the register to its reset state.

Top module: `disp_irq_reg`

## Requirements
- R1: While reset is held, and until the host changes anything after it, all flags and enables are zero, `irq_o` is low and a read returns 0x0000_0000.
- R2: Event input bit k sets status flag k, whatever its enable. The encoding is `evt_i[0]` = vertical-sync end (flag at bit 0), `evt_i[1]` = vertical-sync start (flag at bit 1) and `evt_i[2]` = frame end (flag at bit 2). A flag reads back one set in the cycle after its event pulse.
- R3: A write with a 0 at flag bit k (bits 2..0) clears that flag. A 1 at a flag bit leaves the flag unchanged and never sets it. Bits 3..6 are acknowledge positions with no flag behind them, and writing them has no effect.
- R4: An event pulse in the same cycle as a write that clears its flag leaves the flag set.
- R5: Every write loads the enables from bits 10..8 (bit 8 vertical-sync end, bit 9 vertical-sync start, bit 10 frame end). Without a write the enables hold their value.
- R6: `irq_o` is a register. It is high in the cycle after any flag and its enable are both set, and low in the cycle after no such pair exists.
- R7: Asserting `rd_en_i` returns, on the next cycle, a word with the flags in bits 2..0, the enables in bits 10..8 and zeros everywhere else. Bits 31..11 and 7..3 of a write are ignored. When `rd_en_i` is low, `rd_data_o` is zero on the next cycle, and a read changes no state.
- R8: A write of 0x0000_0600 after a vertical-sync-end interrupt clears all flags and disables only the vertical-sync-end source. A write of zero disables every source and clears every flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 3 | Event pulses: bit 0 vsync end, bit 1 vsync start, bit 2 frame end |
| wr_en_i | input | 1 | Write strobe for the register |
| wr_data_i | input | 32 | Write data: flag acknowledges in 2..0, enables in 10..8 |
| rd_en_i | input | 1 | Read strobe; data appears one cycle later |
| rd_data_o | output | 32 | Read data, zero when no read was requested |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The stimulus table covers several cases. Events arrive with their enables off, which separates latching from reporting. Writes set flag positions to one, which separates "leave alone" from "set". Partial acknowledges clear one flag and keep another. A write and an event arrive in the same cycle, which shows which of the two wins. Enable patterns switch one source off while the others stay on, which exposes a wrong bit mapping between the three sources. Directed tests then check the reset state, a reset in the middle of operation, zero read data when no read is requested, and the extra cycle of interrupt latency. Writes with the upper and unused bits all ones show that those bits cannot leak into the state.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned EVT_COUNT  = 3;
  localparam int unsigned FLAG_BASE  = 0;
  localparam int unsigned ENA_BASE   = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  // Event indices; each index also selects the flag and enable position.
  typedef enum logic [1:0] {
    EV_VSYNC_END   = 2'd0,
    EV_VSYNC_START = 2'd1,
    EV_FRAME_END   = 2'd2
  } evt_idx_e;
endpackage

// File: rtl/disp_irq_rst_sync.sv
module disp_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/disp_irq_flag_cell.sv
module disp_irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic wr_en_i,
  input  logic wr_ack_bit_i,
  input  logic wr_ena_bit_i,
  output logic flag_o,
  output logic ena_o
);
  logic flag_q, flag_d, flag_ce;
  logic ena_q, ena_d, ena_ce;

  // A zero at the acknowledge position clears; an event wins over the clear.
  always_comb begin
    flag_ce = evt_i | (wr_en_i & ~wr_ack_bit_i);
    flag_d  = evt_i;
    ena_ce  = wr_en_i;
    ena_d   = wr_ena_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= 1'b0;
    end else if (ena_ce) begin
      ena_q <= ena_d;
    end
  end

  assign flag_o = flag_q;
  assign ena_o  = ena_q;
endmodule

// File: rtl/disp_irq_merge.sv
module disp_irq_merge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] ena_i,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    irq_d = |(flag_i & ena_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disp_irq_readback.sv
module disp_irq_readback #(
  parameter int unsigned W         = 32,
  parameter int unsigned N         = 3,
  parameter int unsigned FLAG_LSB  = 0,
  parameter int unsigned ENA_LSB   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_en_i,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] ena_i,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0] word;
  logic [W-1:0] rd_d, rd_q;

  always_comb begin
    word = '0;
    for (int k = 0; k < int'(N); k++) begin
      word[FLAG_LSB+k] = flag_i[k];
      word[ENA_LSB+k]  = ena_i[k];
    end
    rd_d = rd_en_i ? word : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/disp_irq_reg.sv
module disp_irq_reg #(
  parameter int unsigned DATA_W      = disp_irq_pkg::REG_W,
  parameter int unsigned NUM_EVT     = disp_irq_pkg::EVT_COUNT,
  parameter int unsigned FLAG_LSB    = disp_irq_pkg::FLAG_BASE,
  parameter int unsigned ENA_LSB     = disp_irq_pkg::ENA_BASE,
  parameter int unsigned SYNC_STAGES = disp_irq_pkg::SYNC_DEPTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic               rst_sync_n;
  logic [NUM_EVT-1:0] flag_vec;
  logic [NUM_EVT-1:0] ena_vec;
  logic               wr_bits_unused;

  // Bits outside the acknowledge and enable fields are deliberately dropped.
  assign wr_bits_unused = ^wr_data_i;

  disp_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_src
    disp_irq_flag_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_sync_n),
      .evt_i        (evt_i[k]),
      .wr_en_i      (wr_en_i),
      .wr_ack_bit_i (wr_data_i[FLAG_LSB+k]),
      .wr_ena_bit_i (wr_data_i[ENA_LSB+k]),
      .flag_o       (flag_vec[k]),
      .ena_o        (ena_vec[k])
    );
  end

  disp_irq_merge #(.N(NUM_EVT)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .flag_i (flag_vec),
    .ena_i  (ena_vec),
    .irq_o  (irq_o)
  );

  disp_irq_readback #(
    .W        (DATA_W),
    .N        (NUM_EVT),
    .FLAG_LSB (FLAG_LSB),
    .ENA_LSB  (ENA_LSB)
  ) u_readback (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .rd_en_i   (rd_en_i),
    .flag_i    (flag_vec),
    .ena_i     (ena_vec),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/disp_irq_reg_chk.sv
module disp_irq_reg_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_EVT  = 3,
  parameter int unsigned FLAG_LSB = 0,
  parameter int unsigned ENA_LSB  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq,
  input logic [NUM_EVT-1:0] flag,
  input logic [NUM_EVT-1:0] ena
);
  logic [DATA_W-1:0] exp_word;
  always_comb begin
    exp_word = '0;
    for (int k = 0; k < int'(NUM_EVT); k++) begin
      exp_word[FLAG_LSB+k] = flag[k];
      exp_word[ENA_LSB+k]  = ena[k];
    end
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_prop
    // R2 / R4: an event always leaves its flag set
    assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> flag[k]);
    // R3: a zero acknowledge without an event clears
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[FLAG_LSB+k] && !evt[k]) |=> !flag[k]);
    // R3: flags never rise without an event
    assert_no_set_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[k] && !flag[k]) |=> !flag[k]);
    // R5: enables hold without a write
    assert_ena_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ena[k]));
  end

  assert_ena_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ena == $past(wr_data[ENA_LSB +: NUM_EVT]));
  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(flag & ena)));
  assert_read_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == $past(exp_word));
  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
endmodule

bind disp_irq_reg disp_irq_reg_chk #(
  .DATA_W   (DATA_W),
  .NUM_EVT  (NUM_EVT),
  .FLAG_LSB (FLAG_LSB),
  .ENA_LSB  (ENA_LSB)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_sync_n),
  .evt     (evt_i),
  .wr_en   (wr_en_i),
  .wr_data (wr_data_i),
  .rd_en   (rd_en_i),
  .rd_data (rd_data_o),
  .irq     (irq_o),
  .flag    (flag_vec),
  .ena     (ena_vec)
);

// File: tb/disp_irq_reg_bench.sv
module disp_irq_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  disp_irq_reg u_disp_irq_reg (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .evt_i     (evt),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // One cycle of write and/or event, then one idle cycle so irq settles.
  task automatic step(input logic w, input logic [31:0] d, input logic [2:0] e);
    wr_en = w; wr_data = d; evt = e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt = '0;
    @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // {write, wdata[31:0], evt[2:0], expected word[31:0], expected irq}
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 3'b001, 32'h0000_0001, 1'b0}, // R2 latched with enable off
    {1'b0, 32'h0000_0000, 3'b110, 32'h0000_0007, 1'b0}, // R2 vsync start + frame end
    {1'b1, 32'h0000_0707, 3'b000, 32'h0000_0707, 1'b1}, // R3 ones keep, R5 enables on
    {1'b1, 32'h0000_0603, 3'b000, 32'h0000_0603, 1'b1}, // R3 partial ack, R5 bit 8 off
    {1'b1, 32'h0000_0600, 3'b000, 32'h0000_0600, 1'b0}, // R3 clear rest, R6 irq drops
    {1'b0, 32'h0000_0000, 3'b001, 32'h0000_0601, 1'b0}, // R6 disabled source no irq
    {1'b0, 32'h0000_0000, 3'b010, 32'h0000_0603, 1'b1}, // R6 enabled source irq
    {1'b1, 32'h0000_0700, 3'b010, 32'h0000_0702, 1'b1}, // R4 event beats clear
    {1'b1, 32'h0000_00FF, 3'b000, 32'h0000_0002, 1'b0}, // R7 bits 7..3 ignored, R5 off
    {1'b1, 32'h0000_0700, 3'b000, 32'h0000_0700, 1'b0}, // R3 clear, enables on
    {1'b0, 32'h0000_0000, 3'b001, 32'h0000_0701, 1'b1}, // R8 vsync end interrupt
    {1'b1, 32'h0000_0600, 3'b000, 32'h0000_0600, 1'b0}, // R8 handler ack + disable
    {1'b0, 32'h0000_0000, 3'b100, 32'h0000_0604, 1'b1}, // R2 frame end
    {1'b1, 32'h0000_0000, 3'b000, 32'h0000_0000, 1'b0}, // R8 zero write
    {1'b1, 32'hFFFF_F800, 3'b000, 32'h0000_0000, 1'b0}  // R7 upper bits ignored
  };

  initial begin
    logic [31:0] v;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk1("R1 irq in reset", irq, 1'b0);
    chk32("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_word(v);
    chk32("R1 word after reset", v, 32'h0);
    chk1("R1 irq after reset", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][68], VEC[i][67:36], VEC[i][35:33]);
      chk1($sformatf("R6 table row %0d irq", i), irq, VEC[i][0]);
      read_word(v);
      chk32($sformatf("R2-R8 table row %0d word", i), v, VEC[i][32:1]);
    end

    // R7: no read strobe gives zero data, and a read does not disturb state
    step(1'b1, 32'h0000_0400, 3'b100);
    chk32("R7 idle rd_data", rd_data, 32'h0);
    read_word(v);
    read_word(v);
    chk32("R7 repeated read", v, 32'h0000_0404);

    // R6: one register of latency after the flag
    step(1'b1, 32'h0000_0000, 3'b000);
    wr_en = 1'b1; wr_data = 32'h0000_0200; evt = 3'b010;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt = '0;
    chk1("R6 irq not yet high", irq, 1'b0);
    @(negedge clk);
    chk1("R6 irq high one cycle later", irq, 1'b1);

    // R1: reset in mid-operation returns to the reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk1("R1 irq on mid reset", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_word(v);
    chk32("R1 word after mid reset", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule